// File: doc/BRIEF.md
# Transmit Frame FIFO with Start Rule and Self-Clearing Flush

This block buffers outgoing frame bytes between a DMA engine that writes them and a MAC transmitter that sends them. Each written byte carries an end-of-frame mark. The block decides on its own when the transmitter may begin sending the frame at the head of the buffer. In whole-frame mode it waits until the frame's final byte is stored. In cut-through mode it starts once a programmable number of bytes is buffered, or earlier if a complete short frame is already present.

A flush command discards everything stored and returns the buffer and the read-side sequencer to their idle state. The flush stays busy for a fixed number of cycles and then clears itself. While it is busy, both byte writes and mode writes are refused. A change of the whole-frame mode bit is recorded at once, but it takes effect only when the transmitter is between frames.

Top module: `tx_frame_fifo`

## Requirements
- R1: After reset, `tx_valid` and `tx_start` are low, `flush_busy` is low and `wr_ready` is high.
- R2: With whole-frame mode off, transmission starts once the buffered byte count reaches the threshold selected by the 3-bit `cfg_thr` code. Codes 0, 1, 2 and 3 select 64, 128, 192 and 256 bytes. Codes 4, 5, 6 and 7 select 40, 32, 24 and 16 bytes.
- R3: With whole-frame mode off, a stored frame that ends below the threshold starts transmission once its end-marked byte is written.
- R4: With whole-frame mode on (`cfg_sf`=1), transmission starts only when an end-marked byte is stored, whatever the threshold code.
- R5: A mode write that arrives during a frame transmission does not change the start rule until that frame has been fully read.
- R6: `tx_start` pulses once per frame. Bytes leave in write order on `tx_data` while `tx_valid` and `tx_ready` are both high, and `tx_last` is high with the end-marked byte.
- R7: A flush request taken while idle holds `flush_busy` high for exactly FLUSH_CYCLES cycles, starting in the cycle after the request. Afterwards the buffer holds no bytes from before the flush.
- R8: While `flush_busy` is high, `wr_ready` is low, byte writes are dropped and mode writes (`cfg_we`) are ignored.
- R9: `wr_ready` is low when DEPTH bytes are stored and no frame has started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write byte present |
| wr_data | input | DATA_W | Write byte |
| wr_last | input | 1 | Byte ends its frame |
| wr_ready | output | 1 | Byte write accepted this cycle |
| cfg_we | input | 1 | Mode write strobe |
| cfg_sf | input | 1 | Whole-frame start mode |
| cfg_thr | input | 3 | Cut-through threshold code |
| flush_req | input | 1 | Flush command |
| flush_busy | output | 1 | Flush in progress; clears itself |
| tx_start | output | 1 | Frame transmission begins |
| tx_valid | output | 1 | Read byte present |
| tx_data | output | DATA_W | Read byte |
| tx_last | output | 1 | Read byte ends its frame |
| tx_ready | input | 1 | Transmitter takes the byte |

## Verification
The hardest case to reach from the ports is a mode write that lands in the middle of a frame transmission. The effect of the deferral shows only in how the next frame starts. To reach it, the bench holds `tx_ready` low so that a cut-through frame stays in its send phase. It writes whole-frame mode at that point, drains the frame, and then shows that an unterminated burst above the threshold no longer starts transmission. The flush case also needs care. A mode write and a byte write are sent while the flush is busy, and their absence is then shown through later start behaviour and the drained byte count.

// File: rtl/tff_pkg.sv
package tff_pkg;
    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    localparam int THR_CODE_W = 3;
    localparam int THR_BYTES_W = 9;
endpackage

// File: rtl/tff_thr_decode.sv
module tff_thr_decode
    import tff_pkg::*;
(
    input  logic [THR_CODE_W-1:0]  code,
    output logic [THR_BYTES_W-1:0] bytes
);
    int v;
    always_comb begin
        // low half: multiples of 64; high half: 40 down to 16 in steps of 8
        if (code[2]) v = 40 - 8 * int'(code[1:0]);
        else         v = 64 * (int'(code[1:0]) + 1);
        bytes = THR_BYTES_W'(v);
    end
endmodule

// File: rtl/tff_flush_timer.sv
module tff_flush_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign busy   = (cnt_q != '0);
    assign accept = req && !busy;

    always_comb begin
        cnt_d = cnt_q;
        if (accept)    cnt_d = CW'(CYCLES);
        else if (busy) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
endmodule

// File: rtl/tff_store.sv
module tff_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [DW-1:0]              push_data,
    input  logic                       push_last,
    input  logic                       pop,
    output logic [DW-1:0]              head_data,
    output logic                       head_last,
    output logic [$clog2(DEPTH):0]     level,
    output logic [$clog2(DEPTH):0]     frames,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [LW-1:0] level;
        logic [LW-1:0] frames;
    } st_t;

    st_t st_d, st_q;
    logic [DW:0] mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push) st_d.wr_ptr = bump(st_q.wr_ptr);
            if (pop)  st_d.rd_ptr = bump(st_q.rd_ptr);
            st_d.level  = st_q.level + LW'(push) - LW'(pop);
            st_d.frames = st_q.frames + LW'(push && push_last)
                                      - LW'(pop && head_last);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[st_q.wr_ptr] <= {push_last, push_data};
    end

    assign {head_last, head_data} = mem[st_q.rd_ptr];
    assign level  = st_q.level;
    assign frames = st_q.frames;
    assign full   = (st_q.level == LW'(DEPTH));
    assign empty  = (st_q.level == '0);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_frames_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frames <= level);
endmodule

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo
    import tff_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int DEPTH        = 256,
    parameter int FLUSH_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    output logic              wr_ready,
    input  logic              cfg_we,
    input  logic              cfg_sf,
    input  logic [2:0]        cfg_thr,
    input  logic              flush_req,
    output logic              flush_busy,
    output logic              tx_start,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    localparam int LW = $clog2(DEPTH) + 1;

    typedef struct packed {
        tx_state_e             state;
        logic                  sf_pend;
        logic                  sf_act;
        logic [THR_CODE_W-1:0] thr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                   flush_accept;
    logic                   push, pop, full, empty, head_last, start_ok;
    logic [LW-1:0]          level, frames;
    logic [THR_BYTES_W-1:0] thr_bytes;

    tff_flush_timer #(.CYCLES(FLUSH_CYCLES)) u_flush (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (flush_req),
        .accept (flush_accept),
        .busy   (flush_busy)
    );

    tff_thr_decode u_thr (
        .code  (ctl_q.thr),
        .bytes (thr_bytes)
    );

    tff_store #(.DW(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (flush_accept || flush_busy),
        .push      (push),
        .push_data (wr_data),
        .push_last (wr_last),
        .pop       (pop),
        .head_data (tx_data),
        .head_last (head_last),
        .level     (level),
        .frames    (frames),
        .full      (full),
        .empty     (empty)
    );

    assign wr_ready = !full && !flush_busy;
    assign push     = wr_valid && wr_ready;
    assign tx_valid = (ctl_q.state == TX_SEND) && !empty && !flush_busy;
    assign tx_last  = tx_valid && head_last;
    assign pop      = tx_valid && tx_ready;

    always_comb begin
        if (ctl_q.sf_act) start_ok = (frames != '0);
        else              start_ok = (frames != '0) ||
                                     (int'(level) >= int'(thr_bytes));
    end

    assign tx_start = (ctl_q.state == TX_IDLE) && !flush_busy && start_ok;

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_we && !flush_busy) begin
            ctl_d.sf_pend = cfg_sf;
            ctl_d.thr     = cfg_thr;
        end
        // the start rule follows the recorded mode only between frames
        if (ctl_q.state == TX_IDLE) ctl_d.sf_act = ctl_q.sf_pend;
        if (flush_accept || flush_busy) begin
            ctl_d.state = TX_IDLE;
        end else if (tx_start) begin
            ctl_d.state = TX_SEND;
        end else if (pop && head_last) begin
            ctl_d.state = TX_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{state: TX_IDLE, sf_pend: 1'b0, sf_act: 1'b0, thr: '0};
        else        ctl_q <= ctl_d;
    end

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_busy) |-> (level == '0));
    p_hold_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> (level == '0));
    p_sf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == TX_SEND && $past(ctl_q.state) == TX_SEND) |-> $stable(ctl_q.sf_act));
    p_thr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_bytes >= THR_BYTES_W'(16)) && (thr_bytes <= THR_BYTES_W'(256)));
endmodule

// File: tb/sim_tx_frame_fifo.sv
module sim_tx_frame_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, wr_last = 1'b0, cfg_we = 1'b0, cfg_sf = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] cfg_thr = '0;
    logic       flush_req = 1'b0, tx_ready = 1'b0;
    logic       wr_ready, flush_busy, tx_start, tx_valid, tx_last;
    logic [7:0] tx_data;

    int checks = 0, fails = 0, starts = 0;

    always #5 clk = ~clk;

    tx_frame_fifo u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_last(wr_last), .wr_ready(wr_ready), .cfg_we(cfg_we), .cfg_sf(cfg_sf),
        .cfg_thr(cfg_thr), .flush_req(flush_req), .flush_busy(flush_busy),
        .tx_start(tx_start), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready)
    );

    always @(negedge clk) if (rst_n && tx_start) starts++;

    typedef struct packed {
        logic       sf;
        logic [2:0] thr;
        logic [8:0] len;
        logic       eof;
        logic       exp;
    } vec_t;

    localparam vec_t VEC [13] = '{
        '{1'b0, 3'd7, 9'd15,  1'b0, 1'b0},
        '{1'b0, 3'd7, 9'd16,  1'b0, 1'b1},
        '{1'b0, 3'd5, 9'd31,  1'b0, 1'b0},
        '{1'b0, 3'd4, 9'd40,  1'b0, 1'b1},
        '{1'b0, 3'd0, 9'd10,  1'b1, 1'b1},
        '{1'b1, 3'd7, 9'd100, 1'b0, 1'b0},
        '{1'b1, 3'd7, 9'd100, 1'b1, 1'b1},
        '{1'b0, 3'd1, 9'd127, 1'b0, 1'b0},
        '{1'b0, 3'd1, 9'd128, 1'b0, 1'b1},
        '{1'b0, 3'd6, 9'd24,  1'b0, 1'b1},
        '{1'b0, 3'd2, 9'd191, 1'b0, 1'b0},
        '{1'b0, 3'd3, 9'd255, 1'b0, 1'b0},
        '{1'b0, 3'd3, 9'd256, 1'b0, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_flush();
        @(negedge clk) flush_req = 1'b1;
        @(negedge clk) flush_req = 1'b0;
        while (flush_busy) @(negedge clk);
    endtask

    task automatic do_cfg(input logic sf, input logic [2:0] thr);
        @(negedge clk) begin cfg_we = 1'b1; cfg_sf = sf; cfg_thr = thr; end
        @(negedge clk) cfg_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic push_frame(input int len, input bit eof);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = 8'(i * 3 + 1);
            wr_last  = eof && (i == len - 1);
        end
        @(negedge clk) begin wr_valid = 1'b0; wr_last = 1'b0; end
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(output int n, output int bad, output bit got_last);
        n = 0; bad = 0; got_last = 0;
        @(negedge clk) tx_ready = 1'b1;
        for (int k = 0; k < 600 && !got_last; k++) begin
            if (tx_valid) begin
                if (tx_data != 8'(n * 3 + 1)) bad++;
                if (tx_last) got_last = 1;
                n++;
            end
            @(negedge clk);
        end
        tx_ready = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int s0, n, bad, cnt;
        bit gl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_valid == 1'b0, "R1 tx_valid", int'(tx_valid), 0);
        check(tx_start == 1'b0, "R1 tx_start", int'(tx_start), 0);
        check(flush_busy == 1'b0, "R1 flush_busy", int'(flush_busy), 0);
        check(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);

        // table of start-rule vectors (R2, R3, R4)
        foreach (VEC[i]) begin
            do_flush();
            do_cfg(VEC[i].sf, VEC[i].thr);
            s0 = starts;
            push_frame(int'(VEC[i].len), VEC[i].eof);
            check((starts - s0) == int'(VEC[i].exp),
                  VEC[i].sf ? "R4 whole-frame start" : (VEC[i].eof ? "R3 short frame start" : "R2 threshold start"),
                  starts - s0, int'(VEC[i].exp));
        end

        // R6 streaming order, R5 deferred mode change
        do_flush();
        do_cfg(1'b0, 3'd7);
        s0 = starts;
        push_frame(20, 1'b1);
        check((starts - s0) == 1, "R6 single start pulse", starts - s0, 1);
        do_cfg(1'b1, 3'd7);
        check(tx_valid == 1'b1, "R5 frame continues after mode write", int'(tx_valid), 1);
        drain(n, bad, gl);
        check(n == 20, "R6 byte count", n, 20);
        check(bad == 0, "R6 byte order", bad, 0);
        check(gl == 1'b1, "R6 tx_last on end byte", int'(gl), 1);
        s0 = starts;
        push_frame(20, 1'b0);
        check((starts - s0) == 0, "R5 new mode applied after frame", starts - s0, 0);
        push_frame(1, 1'b1);
        check((starts - s0) == 1, "R5 whole frame starts", starts - s0, 1);

        // R7, R8 flush behaviour
        do_flush();
        do_cfg(1'b1, 3'd0);
        push_frame(30, 1'b0);
        @(negedge clk) flush_req = 1'b1;
        @(negedge clk) begin
            flush_req = 1'b0;
            check(wr_ready == 1'b0, "R8 wr_ready low in flush", int'(wr_ready), 0);
            cfg_we = 1'b1; cfg_sf = 1'b0; cfg_thr = 3'd7;
            wr_valid = 1'b1; wr_data = 8'hEE; wr_last = 1'b1;
        end
        cnt = 0;
        while (flush_busy && cnt < 100) begin
            cnt++;
            @(negedge clk) begin cfg_we = 1'b0; wr_valid = 1'b0; wr_last = 1'b0; end
        end
        check(cnt == 4, "R7 busy length", cnt, 4);
        check(tx_valid == 1'b0, "R7 nothing to send after flush", int'(tx_valid), 0);
        repeat (3) @(negedge clk);
        s0 = starts;
        push_frame(16, 1'b0);
        check((starts - s0) == 0, "R8 mode write ignored in flush", starts - s0, 0);
        push_frame(1, 1'b1);
        check((starts - s0) == 1, "R8 start after end byte", starts - s0, 1);
        drain(n, bad, gl);
        check(n == 17, "R7 old bytes discarded", n, 17);

        // R9 full
        do_flush();
        do_cfg(1'b1, 3'd3);
        push_frame(256, 1'b0);
        check(wr_ready == 1'b0, "R9 wr_ready low when full", int'(wr_ready), 0);
        do_flush();
        check(wr_ready == 1'b1, "R9 wr_ready back after flush", int'(wr_ready), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule